// File: doc/BRIEF.md
# Quarter-Word Multiply-Accumulate Unit with Flag Generation

This unit is the multiply-accumulate step of a wide-integer datapath. Each operation takes two full-width operands. It picks one quarter-width slice from each, multiplies the two slices and shifts the product left by a whole number of quarter-widths. It then adds the shifted product either to the internal accumulator or to zero. The sum is truncated to the full width. A two-bit mode chooses what happens to the sum:
- mode 00 only accumulates;
- mode 01 writes the whole sum out;
- modes 10 and 11 shift out the low half, which goes to the lower or upper half of the destination word, and keep only the high half in the accumulator.

The register file and the flag registers are outside the unit. For the register file, the unit drives write data and a per-half write strobe. For the flag registers, it drives a four-bit flag value vector and a four-bit flag enable vector. The flag rules depend on the mode, so that a chain of shift-out operations can build up sign, parity and zero information across the words of a long result. A separate load port overwrites the accumulator directly.

Top module: `wide_qmac`

## Requirements
- R1: Quarter k of an operand (k = 0..3, from the 2-bit select) is bits [k*Q+Q-1 : k*Q], where Q = WIDTH/4. Each operand has its own select.
- R2: The Q×Q product is shifted left by shift_i×Q bits, added to the base value, and truncated to WIDTH bits.
- R3: When zero_acc_i is 1, the base value is zero. Otherwise it is the current accumulator.
- R4: Mode 00 updates the accumulator with the sum and drives result_o = sum. It asserts no write strobe and no flag enable.
- R5: Mode 01 drives result_o = sum, half_we_o = 11 and flags_en_o = 1110. It sets M to sum[WIDTH-1], L to sum[0], and Z to sum==0. The accumulator takes the sum.
- R6: Modes 10 and 11 drive both halves of result_o with the low half of the sum. half_we_o is 01 for mode 10 and 10 for mode 11. The accumulator takes the sum shifted right by WIDTH/2, with zeros filled in at the top.
- R7: In mode 10, L takes bit 0 of the low half and Z takes (low half == 0). L and Z are enabled and M is not.
- R8: In mode 11, M takes the top bit of the low half and is enabled, and L is not enabled. Z is enabled only when the low half is nonzero, and then Z is 0.
- R9: The carry flag enable, flags_en_o[0], is never asserted. Flag vector bit order is {Z, L, M, C} from bit 3 down to bit 0.
- R10: When acc_wr_en_i is 1, the next accumulator value is acc_wr_data_i, whatever en_i and the mode are.
- R11: When en_i is 0, half_we_o and flags_en_o are 0. Without acc_wr_en_i, the accumulator also holds.
- R12: An active-low rst_ni clears the accumulator at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | An operation is issued this cycle |
| mode_i | input | 2 | 00 accumulate, 01 write out, 10 shift out to lower half, 11 shift out to upper half |
| op_a_i | input | WIDTH | First operand |
| op_b_i | input | WIDTH | Second operand |
| a_qsel_i | input | 2 | Quarter select for op_a_i |
| b_qsel_i | input | 2 | Quarter select for op_b_i |
| shift_i | input | 2 | Product shift in quarter-width steps |
| zero_acc_i | input | 1 | Add to zero instead of the accumulator |
| acc_wr_en_i | input | 1 | Load the accumulator directly |
| acc_wr_data_i | input | WIDTH | Accumulator load value |
| result_o | output | WIDTH | Write data for the destination word |
| half_we_o | output | 2 | Write strobes, bit 1 upper half, bit 0 lower half |
| flags_o | output | 4 | Flag values {Z, L, M, C} |
| flags_en_o | output | 4 | Flag update enables {Z, L, M, C} |
| acc_o | output | WIDTH | Current accumulator |

## Verification
The clocked properties assume that every input is at a known value at each rising edge and is held stable across it. They also assume that mode_i may be any of its four codes whether en_i is high or low. The stimulus meets this by changing every input only just after a falling edge. It sweeps every mode, both quarter selects, every shift and both zero-accumulate settings on a 32-bit build. Quarters are zeroed at random so that zero results, which drive the Z rules, occur often.

// File: rtl/wide_qmac.sv
module wide_qmac #(
  parameter int WIDTH = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       mode_i,
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  input  logic [1:0]       a_qsel_i,
  input  logic [1:0]       b_qsel_i,
  input  logic [1:0]       shift_i,
  input  logic             zero_acc_i,
  input  logic             acc_wr_en_i,
  input  logic [WIDTH-1:0] acc_wr_data_i,
  output logic [WIDTH-1:0] result_o,
  output logic [1:0]       half_we_o,
  output logic [3:0]       flags_o,
  output logic [3:0]       flags_en_o,
  output logic [WIDTH-1:0] acc_o
);
  localparam int QW = WIDTH / 4;
  localparam int HW = WIDTH / 2;
  localparam int PW = 2 * QW;

  logic [WIDTH-1:0] acc_q, acc_d, base, addend, sum, prod_ext;
  logic [QW-1:0]    qa, qb;
  logic [PW-1:0]    prod;
  logic [HW-1:0]    sum_lo;
  logic             lo_zero, hi_zero, shout, upper, act;

  always_comb begin
    case (a_qsel_i)
      2'd0:    qa = op_a_i[0*QW +: QW];
      2'd1:    qa = op_a_i[1*QW +: QW];
      2'd2:    qa = op_a_i[2*QW +: QW];
      default: qa = op_a_i[3*QW +: QW];
    endcase
    case (b_qsel_i)
      2'd0:    qb = op_b_i[0*QW +: QW];
      2'd1:    qb = op_b_i[1*QW +: QW];
      2'd2:    qb = op_b_i[2*QW +: QW];
      default: qb = op_b_i[3*QW +: QW];
    endcase
  end

  assign prod     = qa * qb;
  assign prod_ext = {{(WIDTH-PW){1'b0}}, prod};

  always_comb begin
    case (shift_i)
      2'd0:    addend = prod_ext;
      2'd1:    addend = prod_ext << QW;
      2'd2:    addend = prod_ext << (2 * QW);
      default: addend = prod_ext << (3 * QW);
    endcase
  end

  assign base    = zero_acc_i ? '0 : acc_q;
  assign sum     = base + addend;
  assign sum_lo  = sum[HW-1:0];
  assign lo_zero = (sum[HW-1:0] == '0);
  assign hi_zero = (sum[WIDTH-1:HW] == '0);

  assign shout = mode_i[1];
  assign upper = mode_i[1] & mode_i[0];
  assign act   = en_i & (mode_i != 2'b00);

  assign result_o = shout ? {sum_lo, sum_lo} : sum;

  always_comb begin
    if (!act)       half_we_o = 2'b00;
    else if (!shout) half_we_o = 2'b11;
    else if (upper) half_we_o = 2'b10;
    else            half_we_o = 2'b01;
  end

  assign flags_o[0] = 1'b0;
  assign flags_o[1] = shout ? sum[HW-1] : sum[WIDTH-1];
  assign flags_o[2] = sum[0];
  assign flags_o[3] = shout ? (~upper & lo_zero) : (lo_zero & hi_zero);

  assign flags_en_o[0] = 1'b0;
  assign flags_en_o[1] = act & (~shout | upper);
  assign flags_en_o[2] = act & (~shout | ~upper);
  assign flags_en_o[3] = act & ~(upper & lo_zero);

  always_comb begin
    if (acc_wr_en_i)  acc_d = acc_wr_data_i;
    else if (shout)   acc_d = {{HW{1'b0}}, sum[WIDTH-1:HW]};
    else              acc_d = sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   acc_q <= '0;
    else if (en_i | acc_wr_en_i)   acc_q <= acc_d;
  end

  assign acc_o = acc_q;
endmodule

module wide_qmac_chk #(
  parameter int WIDTH = 256
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [1:0]       mode_i,
  input logic             acc_wr_en_i,
  input logic [WIDTH-1:0] acc_wr_data_i,
  input logic [1:0]       half_we_o,
  input logic             z_val,
  input logic [3:0]       flags_en_o,
  input logic [WIDTH-1:0] acc_o
);
  localparam int HW = WIDTH / 2;

  AST_CARRY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flags_en_o[0]);  // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (flags_en_o == 4'b0000 && half_we_o == 2'b00));  // R11
  AST_ACC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !acc_wr_en_i) |=> $stable(acc_o));  // R11
  AST_ACC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_wr_en_i |=> acc_o == $past(acc_wr_data_i));  // R10
  AST_NOWB_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b00 |-> (flags_en_o == 4'b0000 && half_we_o == 2'b00));  // R4
  AST_WO_ENABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i == 2'b01) |-> (flags_en_o == 4'b1110 && half_we_o == 2'b11));  // R5
  AST_LOWER_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i == 2'b10) |-> (flags_en_o[2:1] == 2'b10 && half_we_o == 2'b01));  // R7
  AST_UPPER_Z_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i == 2'b11 && flags_en_o[3]) |-> !z_val);  // R8
  AST_SO_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i[1] && !acc_wr_en_i) |=> acc_o[WIDTH-1:HW] == '0);  // R6
endmodule

bind wide_qmac wide_qmac_chk #(.WIDTH(WIDTH)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .mode_i(mode_i),
  .acc_wr_en_i(acc_wr_en_i), .acc_wr_data_i(acc_wr_data_i),
  .half_we_o(half_we_o), .z_val(flags_o[3]), .flags_en_o(flags_en_o),
  .acc_o(acc_o)
);

// File: tb/wide_qmac_tb.sv
module wide_qmac_tb_top;
  localparam int W  = 32;
  localparam int Q  = W / 4;
  localparam int H  = W / 2;

  logic clk = 1'b0, rst_ni = 1'b0, en = 1'b0, zacc = 1'b0, awe = 1'b0;
  logic [1:0] mode = '0, asel = '0, bsel = '0, sh = '0;
  logic [W-1:0] a = '0, b = '0, awd = '0;
  logic [W-1:0] result, acc;
  logic [1:0] hwe;
  logic [3:0] flags, fen;

  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;
  logic [W-1:0] m_acc = '0;

  always #2 clk = ~clk;

  wide_qmac #(.WIDTH(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .mode_i(mode),
    .op_a_i(a), .op_b_i(b), .a_qsel_i(asel), .b_qsel_i(bsel),
    .shift_i(sh), .zero_acc_i(zacc), .acc_wr_en_i(awe), .acc_wr_data_i(awd),
    .result_o(result), .half_we_o(hwe), .flags_o(flags), .flags_en_o(fen),
    .acc_o(acc)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(input logic [W-1:0] va, input logic [W-1:0] vb, input logic [1:0] qa_s,
                    input logic [1:0] qb_s, input logic [1:0] s, input logic z,
                    input logic [1:0] m);
    logic [Q-1:0] qa, qb;
    logic [W-1:0] add, sum, e_res, e_acc;
    logic [H-1:0] lo;
    logic [3:0] e_f, e_en;
    logic [1:0] e_we;
    @(negedge clk);
    a = va; b = vb; asel = qa_s; bsel = qb_s; sh = s; zacc = z; mode = m;
    en = 1'b1; awe = 1'b0;
    qa = Q'(va >> (qa_s * Q));
    qb = Q'(vb >> (qb_s * Q));
    add = W'(W'(qa) * W'(qb)) << (s * Q);
    sum = (z ? '0 : m_acc) + add;
    lo  = sum[H-1:0];
    e_f = 4'b0; e_en = 4'b0;
    case (m)
      2'b00: begin e_res = sum; e_we = 2'b00; e_acc = sum; end
      2'b01: begin
        e_res = sum; e_we = 2'b11; e_acc = sum; e_en = 4'b1110;
        e_f = {sum == '0, sum[0], sum[W-1], 1'b0};
      end
      2'b10: begin
        e_res = {lo, lo}; e_we = 2'b01; e_acc = sum >> H; e_en = 4'b1100;
        e_f = {lo == '0, lo[0], 2'b00};
      end
      default: begin
        e_res = {lo, lo}; e_we = 2'b10; e_acc = sum >> H;
        e_en = {lo != '0, 3'b010};
        e_f = {1'b0, 1'b0, lo[H-1], 1'b0};
      end
    endcase
    #1;
    chk(m[1] ? "R6 result" : (m == 2'b01 ? "R5 result" : "R4 result"), 64'(result), 64'(e_res));
    chk(m == 2'b00 ? "R4 strobes" : "R6 strobes", 64'(hwe), 64'(e_we));
    chk(m == 2'b11 ? "R8 enables" : (m == 2'b10 ? "R7 enables" : "R5 enables"), 64'(fen), 64'(e_en));
    chk(m == 2'b11 ? "R8 flags" : (m == 2'b10 ? "R7 flags" : "R5 flags"),
        64'(flags & e_en), 64'(e_f & e_en));
    @(posedge clk); #1;
    chk(z ? "R3 R1 R2 acc" : "R1 R2 acc", 64'(acc), 64'(e_acc));
    m_acc = e_acc;
  endtask

  task automatic load(input logic [W-1:0] v, input logic with_en);
    @(negedge clk);
    awe = 1'b1; awd = v; en = with_en; mode = 2'b01; zacc = 1'b0;
    @(posedge clk); #1;
    chk("R10 load", 64'(acc), 64'(v));
    m_acc = v;
    @(negedge clk);
    awe = 1'b0; en = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R12 reset acc", 64'(acc), 64'(0));
    @(negedge clk); rst_ni = 1'b1;

    load(32'hDEAD_BEEF, 1'b0);
    load(32'h1234_5678, 1'b1);

    // R11: idle cycles with busy inputs
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      en = 1'b0; mode = 2'(i); a = $urandom; b = $urandom; zacc = 1'(i);
      #1;
      chk("R11 idle enables", 64'({fen, hwe}), 64'(0));
      @(posedge clk); #1;
      chk("R11 idle acc hold", 64'(acc), 64'(m_acc));
    end

    // Directed zero cases for Z rules
    load(32'hABCD_0000, 1'b0);
    op('0, 32'hFFFF_FFFF, 2'd0, 2'd0, 2'd0, 1'b0, 2'b11);  // R8: low half zero -> Z not enabled
    load(32'hABCD_0000, 1'b0);
    op('0, 32'hFFFF_FFFF, 2'd1, 2'd2, 2'd1, 1'b0, 2'b10);  // R7: Z set
    op('0, '0, 2'd0, 2'd0, 2'd0, 1'b1, 2'b01);             // R5: Z set on whole zero
    op(32'hFF00_0000, 32'hFF00_0000, 2'd3, 2'd3, 2'd3, 1'b1, 2'b01);  // R2 truncation

    // Sweep
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 4; s++)
        for (int qa = 0; qa < 4; qa++)
          for (int qb = 0; qb < 4; qb++)
            for (int z = 0; z < 2; z++) begin
              logic [W-1:0] va, vb;
              va = $urandom; vb = $urandom;
              if ($urandom_range(0, 3) == 0) va[qa*Q +: Q] = '0;
              if ($urandom_range(0, 5) == 0) vb = '0;
              op(va, vb, 2'(qa), 2'(qb), 2'(s), 1'(z), 2'(m));
            end

    // R12: asynchronous reset mid-run
    load(32'h0F0F_0F0F, 1'b0);
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R12 async clear", 64'(acc), 64'(0));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule